// File: doc/BRIEF.md
# Strided and Fragmented Payload Address Generator

This block turns one DMA descriptor into the list of payload read bursts that cover its transfer. A start pulse loads the transfer size, the packed line/stride word, the mode bit, the five source address words and the three extension words. The block then presents one (address, length) read command at a time on a valid/ready handshake. It raises a one-cycle done pulse once the whole transfer is covered. A downstream reader that fails on a command reports it on `rdErrIn`. The block then stops issuing and raises a one-cycle error pulse.

Two walking patterns exist. In line mode the block reads fixed-size lines at a constant stride, starting from the first source address. In fragment mode it visits up to five independent source regions. Each region is read from its start to the next 4 KiB page boundary, and the final read is clipped to what remains of the transfer. Source addresses are widened by 12-bit extension fields taken from the extension words. These fields alternate between bits 27:16 shifted left by 20 and bits 11:0 shifted left by 8.

Top module: `payAgenTop`

## Requirements
- R1: After reset `cmdValid`, `busyOut`, `doneOut` and `errOut` are all 0.
- R2: `modeIn` sampled at start selects the pattern: 0 is line mode and 1 is fragment mode. In fragment mode the line size field plays no part.
- R3: In line mode the line size is `lineWordIn[17:0]` and the stride is `lineWordIn[31:18]*16`. Command k has address A0 + k*stride and length equal to the line size. The last command is the one at which the remaining size is no larger than one line. A0 is the composed address of region 0 (see R4).
- R4: Region i's address is source word i plus a 12-bit extension field, added with zero extension. Even i (0, 2, 4) take bits 27:16 shifted left 20. Odd i (1, 3) take bits 11:0 shifted left 8. Region 0 takes its field from extension word 0, regions 1 and 2 from word 1, and regions 3 and 4 from word 2.
- R5: In fragment mode each command length is the smaller of (4096 − address mod 4096) and the remaining size. Regions are issued in order 0..4. Issuing ends when the remaining size is used up or after region 4, whichever comes first.
- R6: A start with transfer size 0, or in line mode with line size 0, issues no command. `doneOut` pulses in the cycle after the start.
- R7: While `cmdValid` is 1 and `cmdReady` is 0, the command address and length stay unchanged.
- R8: `rdErrIn` while busy ends the transfer. `errOut` pulses for one cycle, `doneOut` stays 0 and no further command appears. When the error and the final handshake fall on the same edge, the error wins.
- R9: `doneOut` pulses for one cycle, in the cycle after the handshake of the final command. `busyOut` is 1 from the cycle after the start until that handshake.
- R10: `startIn` while busy is ignored. The current command sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Load descriptor fields and begin |
| modeIn | input | 1 | 0 line mode, 1 fragment mode |
| xferSizeIn | input | 32 | Transfer size in bytes |
| lineWordIn | input | 32 | Line size [17:0], stride/16 [31:18] |
| srcAddrIn | input | NUM_FRAG*32 | Source word i at bits [32i+31:32i] |
| extWordsIn | input | EXT_N*32 | Extension word k at bits [32k+31:32k] |
| cmdValid | output | 1 | Read command valid |
| cmdReady | input | 1 | Reader accepts command |
| cmdAddr | output | ADDR_W | Read command address |
| cmdLen | output | 18 | Read command length in bytes |
| rdErrIn | input | 1 | Reader reports a failed read |
| busyOut | output | 1 | Sequence in progress |
| doneOut | output | 1 | One-cycle pulse: transfer covered |
| errOut | output | 1 | One-cycle pulse: transfer aborted by read failure |

## Verification
Completion of the final command and a read failure can land on the same clock edge. The bench provokes this by raising `rdErrIn` together with `cmdReady` while the last expected command is presented. It then expects only `errOut`, with no `doneOut` and no later command. A second run raises the failure on a middle command and watches several idle cycles for stray commands. A start pulse during a stalled command is also overlapped with an active sequence. The bench checks that the stalled command and all later ones match the first descriptor.

// File: rtl/payAgenPkg.sv
package payAgenPkg;
  localparam int LINE_W       = 18;
  localparam int STRIDE_LSB   = 18;
  localparam int STRIDE_W     = 14;
  localparam int STRIDE_SHIFT = 4;
  localparam int PAGE_BITS    = 12;
  localparam int FIELD_W      = 12;
  localparam int HI_FIELD_LSB = 16;
  localparam int HI_SHIFT     = 20;
  localparam int LO_SHIFT     = 8;

  typedef struct packed {
    logic load;
    logic step;
  } agenStrobeT;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } agenStateT;
endpackage

// File: rtl/payAgenData.sv
module payAgenData
  import payAgenPkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int NUM_FRAG = 5,
  parameter int EXT_N    = (NUM_FRAG + 2) / 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  agenStrobeT                stb,
  input  logic                      modeIn,
  input  logic [31:0]               xferSizeIn,
  input  logic [31:0]               lineWordIn,
  input  logic [NUM_FRAG*32-1:0]    srcAddrIn,
  input  logic [EXT_N*32-1:0]       extWordsIn,
  output logic [ADDR_W-1:0]         cmdAddr,
  output logic [LINE_W-1:0]         cmdLen,
  output logic                      lastCmd,
  output logic                      zeroStart
);
  localparam int FIDX_W  = (NUM_FRAG > 1) ? $clog2(NUM_FRAG) : 1;
  localparam int PAGE_W  = PAGE_BITS + 1;
  localparam int STRD_W  = STRIDE_W + STRIDE_SHIFT;

  logic [ADDR_W-1:0] fragBase  [NUM_FRAG];
  logic [ADDR_W-1:0] fragAddrR [NUM_FRAG];
  logic [ADDR_W-1:0] curAddrR;
  logic [31:0]       remR;
  logic [LINE_W-1:0] lineSizeR;
  logic [STRD_W-1:0] strideR;
  logic [FIDX_W-1:0] fragIdxR;
  logic              modeR;
  logic [PAGE_W-1:0] pageRem;
  logic [EXT_N-1:0]  unusedExtBits;

  // Region address composition: even regions use the high field, odd the low
  for (genvar i = 0; i < NUM_FRAG; i++) begin : g_frag
    localparam int EXT_IDX = (i + 1) / 2;
    logic [FIELD_W-1:0] extField;
    if (i % 2 == 0) begin : g_hi
      assign extField    = extWordsIn[EXT_IDX*32+HI_FIELD_LSB +: FIELD_W];
      assign fragBase[i] = ADDR_W'(srcAddrIn[i*32 +: 32]) + (ADDR_W'(extField) << HI_SHIFT);
    end else begin : g_lo
      assign extField    = extWordsIn[EXT_IDX*32 +: FIELD_W];
      assign fragBase[i] = ADDR_W'(srcAddrIn[i*32 +: 32]) + (ADDR_W'(extField) << LO_SHIFT);
    end
  end

  for (genvar k = 0; k < EXT_N; k++) begin : g_unused
    assign unusedExtBits[k] = ^{extWordsIn[k*32+28 +: 4], extWordsIn[k*32+12 +: 4],
                                (k == 0) ? extWordsIn[k*32 +: FIELD_W] : {FIELD_W{1'b0}}};
  end

  always_comb begin
    cmdAddr = modeR ? fragAddrR[fragIdxR] : curAddrR;
    pageRem = PAGE_W'(1 << PAGE_BITS) - {1'b0, cmdAddr[PAGE_BITS-1:0]};
    if (!modeR) begin
      cmdLen  = lineSizeR;
      lastCmd = (remR <= 32'(lineSizeR));
    end else begin
      cmdLen  = (remR < 32'(pageRem)) ? LINE_W'(remR) : LINE_W'(pageRem);
      lastCmd = (remR <= 32'(pageRem)) || (fragIdxR == FIDX_W'(NUM_FRAG - 1));
    end
    zeroStart = (xferSizeIn == 32'd0) ||
                (!modeIn && (lineWordIn[LINE_W-1:0] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddrR  <= '0;
      remR      <= '0;
      lineSizeR <= '0;
      strideR   <= '0;
      fragIdxR  <= '0;
      modeR     <= 1'b0;
      for (int i = 0; i < NUM_FRAG; i++) fragAddrR[i] <= '0;
    end else if (stb.load) begin
      curAddrR  <= fragBase[0];
      remR      <= xferSizeIn;
      lineSizeR <= lineWordIn[LINE_W-1:0];
      strideR   <= {lineWordIn[STRIDE_LSB +: STRIDE_W], {STRIDE_SHIFT{1'b0}}};
      fragIdxR  <= '0;
      modeR     <= modeIn;
      for (int i = 0; i < NUM_FRAG; i++) fragAddrR[i] <= fragBase[i];
    end else if (stb.step) begin
      if (!modeR) begin
        curAddrR <= curAddrR + ADDR_W'(strideR);
        remR     <= remR - 32'(lineSizeR);
      end else begin
        remR <= remR - 32'(cmdLen);
        if (fragIdxR != FIDX_W'(NUM_FRAG - 1)) fragIdxR <= fragIdxR + 1'b1;
      end
    end
  end

  AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && stb.step)); // R10

  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && !lastCmd |=> remR < $past(remR)); // R5
endmodule

// File: rtl/payAgenCtrl.sv
module payAgenCtrl
  import payAgenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       cmdReady,
  input  logic       rdErrIn,
  input  logic       zeroStart,
  input  logic       lastCmd,
  output agenStrobeT stb,
  output logic       cmdValid,
  output logic       busyOut,
  output logic       doneOut,
  output logic       errOut
);
  agenStateT stateR;

  always_comb begin
    stb.load = (stateR == ST_IDLE) && startIn && !zeroStart;
    stb.step = (stateR == ST_ISSUE) && cmdReady && !rdErrIn;
    cmdValid = (stateR == ST_ISSUE);
    busyOut  = (stateR == ST_ISSUE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR  <= ST_IDLE;
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      errOut  <= 1'b0;
      unique case (stateR)
        ST_IDLE: begin
          if (startIn) begin
            if (zeroStart) doneOut <= 1'b1;
            else           stateR  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (rdErrIn) begin
            errOut <= 1'b1;
            stateR <= ST_IDLE;
          end else if (cmdReady && lastCmd) begin
            doneOut <= 1'b1;
            stateR  <= ST_IDLE;
          end
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  AST_ZERO_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid && startIn && zeroStart |=> doneOut && !cmdValid); // R6

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !cmdValid && !doneOut); // R8

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady && !rdErrIn |=> cmdValid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R9
endmodule

// File: rtl/payAgenTop.sv
module payAgenTop
  import payAgenPkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int NUM_FRAG = 5,
  parameter int EXT_N    = (NUM_FRAG + 2) / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic                   modeIn,
  input  logic [31:0]            xferSizeIn,
  input  logic [31:0]            lineWordIn,
  input  logic [NUM_FRAG*32-1:0] srcAddrIn,
  input  logic [EXT_N*32-1:0]    extWordsIn,
  output logic                   cmdValid,
  input  logic                   cmdReady,
  output logic [ADDR_W-1:0]      cmdAddr,
  output logic [LINE_W-1:0]      cmdLen,
  input  logic                   rdErrIn,
  output logic                   busyOut,
  output logic                   doneOut,
  output logic                   errOut
);
  agenStrobeT stb;
  logic       lastCmd;
  logic       zeroStart;

  payAgenCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmdReady(cmdReady),
    .rdErrIn(rdErrIn), .zeroStart(zeroStart), .lastCmd(lastCmd),
    .stb(stb), .cmdValid(cmdValid), .busyOut(busyOut),
    .doneOut(doneOut), .errOut(errOut)
  );

  payAgenData #(.ADDR_W(ADDR_W), .NUM_FRAG(NUM_FRAG), .EXT_N(EXT_N)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .modeIn(modeIn),
    .xferSizeIn(xferSizeIn), .lineWordIn(lineWordIn),
    .srcAddrIn(srcAddrIn), .extWordsIn(extWordsIn),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .lastCmd(lastCmd), .zeroStart(zeroStart)
  );

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady && !rdErrIn |=> $stable(cmdAddr) && $stable(cmdLen)); // R7

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdLen != '0); // R5

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && errOut)); // R8
endmodule

// File: tb/test_payAgenTop.sv
module test_payAgenTop;
  localparam int ADDR_W = 48;
  localparam int NF     = 5;
  localparam int EN     = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rstN, startIn, modeIn, cmdReady, rdErrIn;
  logic [31:0]        xferSizeIn, lineWordIn;
  logic [NF*32-1:0]   srcAddrIn;
  logic [EN*32-1:0]   extWordsIn;
  logic               cmdValid, busyOut, doneOut, errOut;
  logic [ADDR_W-1:0]  cmdAddr;
  logic [17:0]        cmdLen;

  logic [31:0] src [NF];
  logic [31:0] ext [EN];
  always_comb begin
    for (int i = 0; i < NF; i++) srcAddrIn[i*32 +: 32] = src[i];
    for (int k = 0; k < EN; k++) extWordsIn[k*32 +: 32] = ext[k];
  end

  payAgenTop i_payAgenTop (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeIn(modeIn),
    .xferSizeIn(xferSizeIn), .lineWordIn(lineWordIn),
    .srcAddrIn(srcAddrIn), .extWordsIn(extWordsIn),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .rdErrIn(rdErrIn), .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut)
  );

  int total = 0;
  int bad   = 0;
  longint expA [32];
  longint expL [32];
  int     expN;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint regionAddr(int i);
    longint f;
    if (i % 2 == 0) f = longint'((ext[(i+1)/2] >> 16) & 32'hFFF) << 20;
    else            f = longint'(ext[(i+1)/2] & 32'hFFF) << 8;
    return longint'(src[i]) + f;
  endfunction

  // Expected commands from R3/R4/R5
  task automatic buildExp(bit mode, longint xfer, logic [31:0] lw);
    longint rem = xfer;
    expN = 0;
    if (!mode) begin
      longint line = longint'(lw[17:0]);
      longint strd = longint'(lw[31:18]) * 16;
      longint a    = regionAddr(0);
      if (line == 0) rem = 0;
      while (rem > 0 && expN < 32) begin
        expA[expN] = a; expL[expN] = line; expN++;
        rem = (rem > line) ? rem - line : 0;
        a   = a + strd;
      end
    end else begin
      for (int i = 0; i < NF && rem > 0; i++) begin
        longint a  = regionAddr(i);
        longint pr = 4096 - (a % 4096);
        longint ln = (rem < pr) ? rem : pr;
        expA[expN] = a; expL[expN] = ln; expN++;
        rem = rem - ln;
      end
    end
  endtask

  task automatic setDesc(bit mode, logic [31:0] xfer, logic [31:0] lw);
    modeIn = mode; xferSizeIn = xfer; lineWordIn = lw;
    buildExp(mode, longint'(xfer), lw);
  endtask

  task automatic chkCmd(string req, int k);
    chk(cmdValid === 1'b1, {req, " valid"}, longint'(cmdValid), 1);
    chk(longint'(cmdAddr) == expA[k], {req, " addr"}, longint'(cmdAddr), expA[k]);
    chk(longint'(cmdLen) == expL[k], {req, " len"}, longint'(cmdLen), expL[k]);
  endtask

  task automatic runXfer(string req, bit stall);
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    chk(busyOut === (expN != 0), "R9 busy", longint'(busyOut), longint'(expN != 0));
    for (int k = 0; k < expN; k++) begin
      if (stall) begin
        cmdReady = 1'b0; chkCmd(req, k); @(negedge clk);
      end
      cmdReady = 1'b1;
      chkCmd(stall ? "R7 stalled" : req, k);
      @(negedge clk);
    end
    cmdReady = 1'b0;
    chk(doneOut === 1'b1, "R9 done pulse", longint'(doneOut), 1);
    chk(cmdValid === 1'b0, "R9 no cmd after end", longint'(cmdValid), 0);
    @(negedge clk);
    chk(doneOut === 1'b0, "R9 done one cycle", longint'(doneOut), 0);
  endtask

  task automatic testReset();
    chk(cmdValid === 1'b0, "R1 valid", longint'(cmdValid), 0);
    chk(busyOut === 1'b0, "R1 busy", longint'(busyOut), 0);
    chk(doneOut === 1'b0, "R1 done", longint'(doneOut), 0);
    chk(errOut === 1'b0, "R1 err", longint'(errOut), 0);
  endtask

  task automatic testLine();
    src[0] = 32'h0000_1000; ext[0] = 32'h0005_0000;
    setDesc(1'b0, 32'h300, {14'd32, 18'h100});
    runXfer("R3 line mode R2", 1'b0);
    src[0] = 32'h00AB_0004; ext[0] = 32'h0FFF_FFFF;
    setDesc(1'b0, 32'h250, {14'd3, 18'h100});
    runXfer("R3 partial last line", 1'b1);
  endtask

  task automatic testFrag();
    src[0] = 32'h0000_0F00; src[1] = 32'h2000_0000; src[2] = 32'h3000_0000;
    src[3] = 32'h4000_0010; src[4] = 32'h5000_0000;
    ext[0] = 32'h0001_0000; ext[1] = 32'h0123_00AB; ext[2] = 32'h07FF_0001;
    setDesc(1'b1, 32'd10000, 32'h0);
    runXfer("R4 R5 regions clipped", 1'b0);
    setDesc(1'b1, 32'hFFFF_FFFF, 32'h0);
    runXfer("R5 five region limit", 1'b1);
    setDesc(1'b1, 32'd100, 32'h0);
    runXfer("R5 single short region", 1'b0);
  endtask

  task automatic testZero();
    src[0] = 32'h0000_2000;
    setDesc(1'b0, 32'd500, {14'd4, 18'h0});
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    chk(cmdValid === 1'b0, "R6 zero line no cmd", longint'(cmdValid), 0);
    chk(doneOut === 1'b1, "R6 zero line done", longint'(doneOut), 1);
    @(negedge clk);
    setDesc(1'b1, 32'd0, 32'h0);
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    chk(cmdValid === 1'b0, "R6 zero size no cmd", longint'(cmdValid), 0);
    chk(doneOut === 1'b1, "R6 zero size done", longint'(doneOut), 1);
    @(negedge clk);
  endtask

  task automatic testErr(int errAt, string req);
    src[0] = 32'h0010_0000; ext[0] = 32'h0;
    setDesc(1'b0, 32'h30, {14'd1, 18'h10});
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    for (int k = 0; k < errAt; k++) begin
      cmdReady = 1'b1; chkCmd(req, k); @(negedge clk);
    end
    cmdReady = 1'b1; rdErrIn = 1'b1;
    @(negedge clk);
    rdErrIn = 1'b0; cmdReady = 1'b1;
    chk(errOut === 1'b1, {req, " err pulse"}, longint'(errOut), 1);
    chk(doneOut === 1'b0, {req, " no done"}, longint'(doneOut), 0);
    for (int j = 0; j < 3; j++) begin
      chk(cmdValid === 1'b0, {req, " no cmd after abort"}, longint'(cmdValid), 0);
      @(negedge clk);
      chk(doneOut === 1'b0 && errOut === 1'b0, {req, " quiet"},
          longint'({doneOut, errOut}), 0);
    end
    cmdReady = 1'b0;
  endtask

  task automatic testBusyStart();
    src[0] = 32'h0000_4000; ext[0] = 32'h0;
    setDesc(1'b0, 32'h40, {14'd2, 18'h20});
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    cmdReady = 1'b0;
    src[0] = 32'h7777_0000; modeIn = 1'b1; xferSizeIn = 32'd9; startIn = 1'b1;
    chkCmd("R10 before", 0);
    @(negedge clk); startIn = 1'b0;
    chkCmd("R10 start ignored", 0);
    cmdReady = 1'b1; @(negedge clk);
    chkCmd("R10 sequence kept", 1);
    @(negedge clk); cmdReady = 1'b0;
    chk(doneOut === 1'b1, "R10 done", longint'(doneOut), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; startIn = 1'b0; modeIn = 1'b0; cmdReady = 1'b0; rdErrIn = 1'b0;
    xferSizeIn = '0; lineWordIn = '0;
    for (int i = 0; i < NF; i++) src[i] = '0;
    for (int k = 0; k < EN; k++) ext[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLine();
    testFrag();
    testZero();
    testErr(1, "R8 mid abort");
    testErr(2, "R8 error with last handshake");
    testBusyStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule